// File: doc/BRIEF.md
# I2C Target with 7-bit and 10-bit Address Matching

This block is the target (slave) side of a two-wire serial bus. It watches the clock and data lines through synchronizers and detects START and STOP conditions. It drives each line through a pull-low enable, so an external open-drain pad and pull-up resistor complete the wire. After every START it listens for an address. It answers to one configured 7-bit address and to one configured 10-bit address, and it handles the two-byte 10-bit sequence. That sequence includes the combined format: a write addresses the target, then a repeated START carries a read header.

Bytes written by the bus controller go to a one-entry receive register, offered to the user with a valid/ready pair. A byte arrives while that register is still full is refused with a NAK. In read transfers the target asks the user for each byte through a valid/ready pair. If no byte is offered, it holds SCL low after the acknowledge phase until one arrives. It then shifts the byte out MSB first.

Top module: `i2c_target_10b`

## Requirements
- R1: After reset both pull-low outputs are released, `rx_valid_o` is low and `tx_ready_o` is low.
- R2: A first byte after START whose upper seven bits equal `addr7_i` is acknowledged by pulling SDA low during the ninth clock. Its bit 0 selects the direction: 0 for write, 1 for read.
- R3: An address byte that matches nothing is not acknowledged. SDA stays released for the rest of that transfer, and no byte is delivered to the user.
- R4: A first byte of the form 11110, then `addr10_i[9:8]`, then 0, is acknowledged. A following byte equal to `addr10_i[7:0]` is acknowledged. Later bytes are write data.
- R5: In a 10-bit sequence, a wrong second byte is not acknowledged. A read header 11110, `addr10_i[9:8]`, 1 is acknowledged only if a full 10-bit write address matched since the last STOP.
- R6: Each accepted write byte, assembled MSB first, appears on `rx_data_o` with `rx_valid_o` high. Both hold until a cycle with `rx_ready_i` high.
- R7: In a read, after each acknowledge the target holds SCL low from the next SCL fall until the user offers a byte. A byte is taken in a cycle with both `tx_valid_i` and `tx_ready_o` high.
- R8: Read data goes out MSB first, and SDA changes only while SCL is low.
- R9: A master ACK (SDA low on the ninth clock of a read byte) requests another byte. A master NAK makes the target release both lines until the next START or STOP.
- R10: A write byte that arrives while `rx_valid_o` is still high is not acknowledged, and the held byte stays unchanged.
- R11: A START or repeated START in any state makes the target treat the next byte as an address.
- R12: A first byte that begins with 11110 is always decoded as a 10-bit header, even when `addr7_i` has that form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the clock wire |
| sda_i | input | 1 | Sampled level of the data wire |
| scl_pull_o | output | 1 | High to pull the clock wire low (stretch) |
| sda_pull_o | output | 1 | High to pull the data wire low |
| addr7_i | input | 7 | Configured 7-bit address |
| addr10_i | input | 10 | Configured 10-bit address |
| rx_data_o | output | 8 | Received write byte |
| rx_valid_o | output | 1 | Received byte is held and valid |
| rx_ready_i | input | 1 | User takes the received byte |
| tx_data_i | input | 8 | Byte to send in a read |
| tx_valid_i | input | 1 | User offers a byte to send |
| tx_ready_o | output | 1 | Target is waiting for a byte (SCL held) |

## Verification
The bench runs a bus controller model against a wired-AND bus and targets these corner cases:
- A 10-bit read header sent with no preceding 10-bit write. A design that ignores the history would acknowledge it.
- A wrong low address byte. A design that checks only the header would accept it.
- A repeated START in the middle of a write. Here the next byte must be decoded as an address, not stored as data.
- A 7-bit configured address of the 11110 form, which must not match.
- A read with no byte offered by the user. The bench confirms that SCL is held low after the controller releases it, and that the late byte still arrives intact.
- A second write byte while the receive register is full. It must be refused without corrupting the held byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned A7_W   = 7;
  localparam int unsigned A10_W  = 10;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [4:0]  TAG10  = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TXLD,
    ST_TX
  } st_e;

  typedef enum logic [1:0] {
    PH_ADR1,
    PH_ADR2,
    PH_WDAT
  } ph_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // one stage beyond the synchronizer keeps the previous level
  logic [STAGES:0] scl_sh, sda_sh;
  logic scl_c, scl_p, sda_c, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  assign scl_c = scl_sh[STAGES-1];
  assign scl_p = scl_sh[STAGES];
  assign sda_c = sda_sh[STAGES-1];
  assign sda_p = sda_sh[STAGES];

  assign sda_o      = sda_c;
  assign scl_rise_o = scl_c & ~scl_p;
  assign scl_fall_o = ~scl_c & scl_p;
  assign start_o    = scl_c & scl_p & sda_p & ~sda_c;
  assign stop_o     = scl_c & scl_p & ~sda_p & sda_c;
endmodule

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match
  import i2c_tgt_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [A7_W-1:0]   addr7_i,
  input  logic [A10_W-1:0]  addr10_i,
  output logic              hit7_o,
  output logic              hi10_o,
  output logic              lo10_o
);
  logic is_tag;

  assign is_tag = (byte_i[BYTE_W-1 -: 5] == TAG10);
  // a header with the 10-bit tag is never taken as a 7-bit address
  assign hit7_o = !is_tag && (byte_i[BYTE_W-1:1] == addr7_i);
  assign hi10_o = is_tag && (byte_i[2:1] == addr10_i[A10_W-1 -: 2]);
  assign lo10_o = (byte_i == addr10_i[BYTE_W-1:0]);
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic [BYTE_W-1:0] shift_o,
  input  logic              hit7_i,
  input  logic              hi10_i,
  input  logic              lo10_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              sda_pull_o,
  output logic              scl_pull_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  st_e               st_q;
  ph_e               ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, rx_data_q;
  logic              ack_q, rd_q, m10_q, nak_q, rx_valid_q;
  logic              ack_d, rd_d, push;
  ph_e               ph_d;

  // acknowledge decision for the byte just shifted in
  always_comb begin
    ack_d = 1'b0;
    rd_d  = 1'b0;
    ph_d  = PH_WDAT;
    unique case (ph_q)
      PH_ADR1: begin
        if (hit7_i) begin
          ack_d = 1'b1;
          rd_d  = sh_q[0];
        end else if (hi10_i) begin
          if (!sh_q[0]) begin
            ack_d = 1'b1;
            ph_d  = PH_ADR2;
          end else if (m10_q) begin
            ack_d = 1'b1;
            rd_d  = 1'b1;
          end
        end
      end
      PH_ADR2: ack_d = lo10_i;
      PH_WDAT: ack_d = !rx_valid_q;
      default: ack_d = 1'b0;
    endcase
  end

  assign push = (st_q == ST_RX) && scl_fall_i && (cnt_q == LAST) &&
                (ph_q == PH_WDAT) && ack_d && !start_i && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ph_q  <= PH_ADR1;
      cnt_q <= '0;
      sh_q  <= '0;
      ack_q <= 1'b0;
      rd_q  <= 1'b0;
      m10_q <= 1'b0;
      nak_q <= 1'b0;
    end else if (start_i) begin
      st_q  <= ST_RX;
      ph_q  <= PH_ADR1;
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else if (stop_i) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
      m10_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise_i && cnt_q != LAST) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == LAST) begin
            ack_q <= ack_d;
            rd_q  <= rd_d;
            st_q  <= ST_RXACK;
            if (ph_q == PH_ADR1) ph_q <= ph_d;
            if (ph_q == PH_ADR2) begin
              ph_q <= PH_WDAT;
              if (ack_d) m10_q <= 1'b1;
            end
          end
        end
        ST_RXACK: begin
          if (scl_fall_i) begin
            cnt_q <= '0;
            ack_q <= 1'b0;
            if (!ack_q)    st_q <= ST_IDLE;
            else if (rd_q) st_q <= ST_TXLD;
            else           st_q <= ST_RX;
          end
        end
        ST_TXLD: begin
          if (tx_valid_i) begin
            sh_q  <= tx_data_i;
            cnt_q <= '0;
            st_q  <= ST_TX;
          end
        end
        ST_TX: begin
          if (scl_rise_i && cnt_q == LAST) begin
            nak_q <= sda_i;
          end else if (scl_fall_i) begin
            if (cnt_q == LAST) begin
              st_q <= nak_q ? ST_IDLE : ST_TXLD;
            end else begin
              sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_q  <= '0;
      rx_valid_q <= 1'b0;
    end else if (push) begin
      rx_data_q  <= sh_q;
      rx_valid_q <= 1'b1;
    end else if (rx_ready_i) begin
      rx_valid_q <= 1'b0;
    end
  end

  assign shift_o    = sh_q;
  assign rx_data_o  = rx_data_q;
  assign rx_valid_o = rx_valid_q;
  assign tx_ready_o = (st_q == ST_TXLD);
  assign scl_pull_o = (st_q == ST_TXLD);
  assign sda_pull_o = ((st_q == ST_RXACK) && ack_q) ||
                      ((st_q == ST_TX) && (cnt_q != LAST) && !sh_q[BYTE_W-1]);
endmodule

// File: rtl/i2c_target_10b.sv
module i2c_target_10b
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic [A7_W-1:0]   addr7_i,
  input  logic [A10_W-1:0]  addr10_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o
);
  logic sda_s, scl_rise, scl_fall, start, stop;
  logic hit7, hi10, lo10;
  logic [BYTE_W-1:0] shift;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_tgt_match i_match (
    .byte_i(shift), .addr7_i, .addr10_i,
    .hit7_o(hit7), .hi10_o(hi10), .lo10_o(lo10)
  );

  i2c_tgt_fsm i_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .shift_o(shift),
    .hit7_i(hit7), .hi10_i(hi10), .lo10_i(lo10),
    .rx_data_o, .rx_valid_o, .rx_ready_i,
    .tx_data_i, .tx_valid_i, .tx_ready_o,
    .sda_pull_o, .scl_pull_o
  );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       sda_pull_o,
  input logic       rx_valid_o,
  input logic       rx_ready_i,
  input logic [7:0] rx_data_o,
  input logic [7:0] tx_data_i,
  input logic       tx_valid_i,
  input logic       tx_ready_o
);
  // R8
  sda_low_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_o) |-> !$past(scl_i));

  // R8
  tx_msb_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> (sda_pull_o == !$past(tx_data_i[7])));

  // R7
  tx_take_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  // R6
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

  // R6
  rx_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_valid_o) |-> sda_pull_o);
endmodule

bind i2c_target_10b i2c_tgt_chk i_chk (.*);

// File: tb/test_i2c_target_10b.sv
module test_i2c_target_10b;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       scl_bus, sda_bus, scl_pull, sda_pull;
  logic [6:0] addr7 = 7'h3A;
  logic [9:0] addr10 = 10'h2C7;
  logic [7:0] rx_data, tx_data = 8'h00;
  logic       rx_valid, rx_ready = 1'b0, tx_valid = 1'b0, tx_ready;
  int         checks = 0, errors = 0;

  always #5 clk = ~clk;

  assign scl_bus = scl_m & ~scl_pull;
  assign sda_bus = sda_m & ~sda_pull;

  i2c_target_10b i_i2c_target_10b (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
    .addr7_i(addr7), .addr10_i(addr10),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b;
    wclk(H);
    scl_m = 1'b1;
    wclk(1);
    while (!scl_bus) @(negedge clk);
    wclk(H / 2);
    r = sda_bus;
    wclk(H / 2);
    scl_m = 1'b0;
  endtask

  task automatic m_start;
    sda_m = 1'b1;
    wclk(H);
    scl_m = 1'b1;
    wclk(H);
    sda_m = 1'b0;
    wclk(H);
    scl_m = 1'b0;
    wclk(H);
  endtask

  task automatic m_stop;
    sda_m = 1'b0;
    wclk(H);
    scl_m = 1'b1;
    wclk(H);
    sda_m = 1'b1;
    wclk(2 * H);
  endtask

  task automatic m_wr(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(b[i], r);
    m_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic m_rd(input logic nak, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, r);
      b[i] = r;
    end
    m_bit(nak, r);
  endtask

  task automatic feed(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic drain;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 sda_pull", sda_pull, 0);
    chk("R1 scl_pull", scl_pull, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_ready", tx_ready, 0);
  endtask

  task automatic t_w7;
    logic a;
    m_start;
    m_wr(8'h74, a); chk("R2 addr7 ack", a, 1);
    m_wr(8'hA5, a); chk("R6 data ack", a, 1);
    chk("R6 rx_valid", rx_valid, 1);
    chk("R6 rx_data", rx_data, 8'hA5);
    drain;
    chk("R6 drained", rx_valid, 0);
    m_stop;
  endtask

  task automatic t_miss7;
    logic a;
    m_start;
    m_wr(8'h76, a); chk("R3 miss nak", a, 0);
    m_wr(8'h00, a); chk("R3 data nak", a, 0);
    chk("R3 no rx", rx_valid, 0);
    m_stop;
  endtask

  task automatic t_w10;
    logic a;
    m_start;
    m_wr(8'hF4, a); chk("R4 hdr ack", a, 1);
    m_wr(8'hC7, a); chk("R4 low ack", a, 1);
    m_wr(8'h5C, a); chk("R4 data ack", a, 1);
    chk("R4 rx_data", rx_data, 8'h5C);
    drain;
    m_stop;
  endtask

  task automatic t_miss10;
    logic a;
    m_start;
    m_wr(8'hF4, a); chk("R5 hdr ack", a, 1);
    m_wr(8'hC8, a); chk("R5 low nak", a, 0);
    m_stop;
    m_start;
    m_wr(8'hF5, a); chk("R5 rd hdr w/o write nak", a, 0);
    m_stop;
  endtask

  task automatic t_r10;
    logic a;
    logic [7:0] b;
    m_start;
    m_wr(8'hF4, a);
    m_wr(8'hC7, a);
    m_start;
    m_wr(8'hF5, a); chk("R5 rd hdr ack", a, 1);
    fork
      m_rd(1'b0, b);
      feed(8'h96);
    join
    chk("R8 read byte", b, 8'h96);
    fork
      m_rd(1'b1, b);
      feed(8'h3C);
    join
    chk("R9 after master ack", b, 8'h3C);
    wclk(4);
    chk("R9 sda released", sda_pull, 0);
    chk("R9 scl released", scl_pull, 0);
    m_stop;
  endtask

  task automatic t_stretch;
    logic a;
    logic [7:0] b;
    m_start;
    m_wr(8'h75, a); chk("R2 read ack", a, 1);
    fork
      m_rd(1'b1, b);
      begin
        wclk(60);
        chk("R7 scl held", scl_pull, 1);
        chk("R7 bus low", scl_bus, 0);
        feed(8'hE1);
      end
    join
    chk("R8 stretched byte", b, 8'hE1);
    m_stop;
  endtask

  task automatic t_full;
    logic a;
    m_start;
    m_wr(8'h74, a);
    m_wr(8'h11, a); chk("R10 first ack", a, 1);
    m_wr(8'h22, a); chk("R10 full nak", a, 0);
    chk("R10 held byte", rx_data, 8'h11);
    drain;
    m_stop;
  endtask

  task automatic t_restart;
    logic a;
    m_start;
    m_wr(8'h74, a);
    m_wr(8'h33, a);
    drain;
    m_start;
    m_wr(8'h76, a); chk("R11 addr after rstart", a, 0);
    m_start;
    m_wr(8'h74, a); chk("R11 re-addr ack", a, 1);
    m_wr(8'h44, a);
    chk("R11 data", rx_data, 8'h44);
    drain;
    m_stop;
  endtask

  task automatic t_tag7;
    logic a;
    addr7 = 7'h78;
    m_start;
    m_wr(8'hF0, a); chk("R12 tag form nak", a, 0);
    m_stop;
    addr7 = 7'h3A;
  endtask

  initial begin
    wclk(3);
    rst_n = 1'b1;
    wclk(3);
    t_reset;
    t_w7;
    t_miss7;
    t_w10;
    t_miss10;
    t_r10;
    t_stretch;
    t_full;
    t_restart;
    t_tag7;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=1 exp=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule